// File: doc/BRIEF.md
# Time-of-Day Counter with Fractional Nanosecond Step

This block keeps a running time of day for a precision timing protocol engine. Time is held as whole seconds plus nanoseconds, and both fields move forward on every cycle of the timestamp clock. When the clock period is a whole number of nanoseconds, one fixed step is enough. When it is not, the block adds a programmed number of normal steps and then one alternate step, and repeats that pattern. The long-run average then matches the true period. For example, an 8.33 ns period is covered by adding 8, 8, 9 over and over.

Software sets the start time and the step settings through one write port with a two-bit select. A read strobe captures both time fields on the same clock edge, so a seconds carry cannot tear the returned value. The nanoseconds field wraps at one billion and carries into seconds.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds field, the nanoseconds field, all step settings, `rd_sec`, `rd_ns` and `rd_valid` are zero. Time therefore stays at zero until steps are programmed.
- R2: A write with `wr_sel`=0 loads seconds from `wr_data[47:0]`. A write with `wr_sel`=1 loads nanoseconds from `wr_data[29:0]`. In that cycle the other field holds its value and time does not advance.
- R3: In every cycle without a write to select 0, 1 or 2, the nanoseconds field grows by the current step.
- R4: A write with `wr_sel`=2 sets the normal step from `wr_data[7:0]`, the alternate step from `wr_data[15:8]` and the repeat count N from `wr_data[23:16]`. Time does not advance in that cycle. With N>0, the steps run as N normal steps and then one alternate step, and this repeats. Normal 8, alternate 9 and N=2 give 8, 8, 9, 8, 8, 9.
- R5: With N=0 the alternate step is never used, and every advancing cycle adds the normal step.
- R6: When nanoseconds plus the step reaches or passes 1,000,000,000, the nanoseconds field takes the sum minus 1,000,000,000. Seconds increases by one in the same cycle.
- R7: A write with select 0, 1 or 2 restarts the step pattern. The first advancing cycle after it counts as the first normal step.
- R8: When `rd_en` is high at a clock edge, `rd_sec` and `rd_ns` show on the next cycle the two fields as they were just before that edge, with `rd_valid` high for one cycle. Otherwise `rd_valid` is low and `rd_sec` and `rd_ns` hold their values.
- R9: A write with `wr_sel`=3 has no effect. Time advances and the pattern continues as if no write had happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 seconds, 1 nanoseconds, 2 step settings, 3 none |
| wr_data | input | 48 | Write data |
| rd_en | input | 1 | Read capture strobe |
| rd_valid | output | 1 | Captured time valid, one cycle after `rd_en` |
| rd_sec | output | 48 | Captured seconds |
| rd_ns | output | 30 | Captured nanoseconds |

## Verification
The assertions check the following on every cycle:
- The read capture and hold timing.
- The rule that seconds moves by at most one while time runs, and that it moves only when nanoseconds wrapped down.
- The alternate step is never picked with a zero count, and never twice in a row.

Only the bench scenarios can show whether the step sequence is right: 8, 8, 9 with a count of two, the normal step alone with a count of zero, and a restart after each write. They also show the exact value after the billion wrap and that a select-3 write has no effect. The bench compares every cycle's read outputs against a model written from the requirements.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    SEL_SEC  = 2'd0,
    SEL_NS   = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  localparam int unsigned NS_PER_SEC = 32'd1000000000;

endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs #(
  parameter int STEP_W = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic [STEP_W-1:0] norm_step,
  output logic [STEP_W-1:0] alt_step,
  output logic [CNT_W-1:0]  rep_cnt
);

  localparam int ALT_LSB = STEP_W;
  localparam int CNT_LSB = 2 * STEP_W;

  logic [STEP_W-1:0] norm_d, alt_d;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    norm_d = norm_step;
    alt_d  = alt_step;
    cnt_d  = rep_cnt;
    if (load) begin
      norm_d = data[STEP_W-1:0];
      alt_d  = data[ALT_LSB +: STEP_W];
      cnt_d  = data[CNT_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_step <= '0;
      alt_step  <= '0;
      rep_cnt   <= '0;
    end else begin
      norm_step <= norm_d;
      alt_step  <= alt_d;
      rep_cnt   <= cnt_d;
    end
  end

endmodule

// File: rtl/tod_step_gen.sv
module tod_step_gen #(
  parameter int STEP_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic [STEP_W-1:0] norm_step,
  input  logic [STEP_W-1:0] alt_step,
  input  logic [CNT_W-1:0]  rep_cnt,
  output logic [STEP_W-1:0] step,
  output logic              alt_sel
);

  logic [CNT_W-1:0] run_q, run_d;
  logic             alt_on;

  assign alt_on = (rep_cnt != '0);

  always_comb begin
    alt_sel = alt_on && (run_q == rep_cnt);
    step    = alt_sel ? alt_step : norm_step;
    run_d   = run_q;
    if (restart) begin
      run_d = '0;
    end else if (adv) begin
      if (alt_sel || !alt_on) run_d = '0;
      else                    run_d = run_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/tod_time_acc.sv
module tod_time_acc #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int STEP_W = 8,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_sec,
  input  logic              load_ns,
  input  logic              adv,
  input  logic [DATA_W-1:0] data,
  input  logic [STEP_W-1:0] step,
  output logic [SEC_W-1:0]  sec_q,
  output logic [NS_W-1:0]   ns_q
);

  import tod_pkg::*;

  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] WRAP = SUM_W'(NS_PER_SEC);

  logic [SUM_W-1:0] ns_sum;
  logic [SEC_W-1:0] sec_d;
  logic [NS_W-1:0]  ns_d;

  assign ns_sum = {1'b0, ns_q} + {{(SUM_W-STEP_W){1'b0}}, step};

  always_comb begin
    sec_d = sec_q;
    ns_d  = ns_q;
    if (load_sec) begin
      sec_d = data[SEC_W-1:0];
    end else if (load_ns) begin
      ns_d = data[NS_W-1:0];
    end else if (adv) begin
      if (ns_sum >= WRAP) begin
        ns_d  = NS_W'(ns_sum - WRAP);
        sec_d = sec_q + SEC_W'(1);
      end else begin
        ns_d = ns_sum[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

endmodule

// File: rtl/tod_read_snap.sv
module tod_read_snap #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [SEC_W-1:0] sec_in,
  input  logic [NS_W-1:0]  ns_in,
  output logic             valid,
  output logic [SEC_W-1:0] sec_out,
  output logic [NS_W-1:0]  ns_out
);

  logic [SEC_W-1:0] sec_d;
  logic [NS_W-1:0]  ns_d;

  always_comb begin
    sec_d = cap ? sec_in : sec_out;
    ns_d  = cap ? ns_in  : ns_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      sec_out <= '0;
      ns_out  <= '0;
    end else begin
      valid   <= cap;
      sec_out <= sec_d;
      ns_out  <= ns_d;
    end
  end

endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int STEP_W = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [SEC_W-1:0]  rd_sec,
  output logic [NS_W-1:0]   rd_ns
);

  import tod_pkg::*;

  logic rst_meta, rst_q;
  logic wr_s, wr_n, wr_c, any_wr, adv;
  logic [STEP_W-1:0] norm_step, alt_step, step;
  logic [CNT_W-1:0]  cfg_cnt;
  logic              alt_sel;
  logic [SEC_W-1:0]  sec_q;
  logic [NS_W-1:0]   ns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    wr_s   = wr_en && (wr_sel == SEL_SEC);
    wr_n   = wr_en && (wr_sel == SEL_NS);
    wr_c   = wr_en && (wr_sel == SEL_CFG);
    any_wr = wr_s || wr_n || wr_c;
    adv    = !any_wr;
  end

  tod_cfg_regs #(.STEP_W(STEP_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_q), .load(wr_c), .data(wr_data),
    .norm_step(norm_step), .alt_step(alt_step), .rep_cnt(cfg_cnt)
  );

  tod_step_gen #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_step (
    .clk(clk), .rst_n(rst_q), .restart(any_wr), .adv(adv),
    .norm_step(norm_step), .alt_step(alt_step), .rep_cnt(cfg_cnt),
    .step(step), .alt_sel(alt_sel)
  );

  tod_time_acc #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_q), .load_sec(wr_s), .load_ns(wr_n), .adv(adv),
    .data(wr_data), .step(step), .sec_q(sec_q), .ns_q(ns_q)
  );

  tod_read_snap #(.SEC_W(SEC_W), .NS_W(NS_W)) u_rd (
    .clk(clk), .rst_n(rst_q), .cap(rd_en), .sec_in(sec_q), .ns_in(ns_q),
    .valid(rd_valid), .sec_out(rd_sec), .ns_out(rd_ns)
  );

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             any_wr,
  input logic             alt_sel,
  input logic [CNT_W-1:0] cfg_cnt,
  input logic [SEC_W-1:0] sec_q,
  input logic [NS_W-1:0]  ns_q,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [SEC_W-1:0] rd_sec,
  input logic [NS_W-1:0]  rd_ns
);

  assert_rd_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid && rd_sec == $past(sec_q) && rd_ns == $past(ns_q)));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_sec) && $stable(rd_ns)));

  assert_alt_needs_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alt_sel |-> (cfg_cnt != '0));

  assert_alt_not_twice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel && !any_wr) |=> !alt_sel);

  assert_sec_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1)));

  assert_carry_with_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(any_wr) && sec_q != $past(sec_q)) |-> (ns_q < $past(ns_q)));

endmodule

bind tod_clock tod_clock_chk #(.SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .any_wr(any_wr), .alt_sel(alt_sel), .cfg_cnt(cfg_cnt),
  .sec_q(sec_q), .ns_q(ns_q), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_sec(rd_sec), .rd_ns(rd_ns)
);

// File: tb/sim_tod_clock.sv
module sim_tod_clock;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [47:0] wr_data;
  logic        rd_en;
  logic        rd_valid;
  logic [47:0] rd_sec;
  logic [29:0] rd_ns;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit m_on  = 0;

  logic [63:0] m_sec, m_ns, m_rs, m_rn;
  logic        m_rv;
  logic [7:0]  m_norm, m_alt, m_k, m_cnt;

  tod_clock u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_ns(rd_ns)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model built from the requirements
  always @(posedge clk) begin
    if (m_on) begin
      logic [63:0] st;
      if (rd_en) begin
        m_rs = m_sec;
        m_rn = m_ns;
      end
      m_rv = rd_en;
      if (wr_en && wr_sel != 2'd3) begin
        if (wr_sel == 2'd0) m_sec = {16'd0, wr_data};
        if (wr_sel == 2'd1) m_ns  = {34'd0, wr_data[29:0]};
        if (wr_sel == 2'd2) begin
          m_norm = wr_data[7:0];
          m_alt  = wr_data[15:8];
          m_k    = wr_data[23:16];
        end
        m_cnt = 8'd0;
      end else begin
        if (m_k != 0 && m_cnt == m_k) begin
          st    = {56'd0, m_alt};
          m_cnt = 8'd0;
        end else begin
          st = {56'd0, m_norm};
          if (m_k != 0) m_cnt = m_cnt + 8'd1;
        end
        m_ns = m_ns + st;
        if (m_ns >= 64'd1000000000) begin
          m_ns  = m_ns - 64'd1000000000;
          m_sec = (m_sec + 64'd1) & 64'hFFFF_FFFF_FFFF;
        end
      end
    end
  end

  task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare read port against the model, sampled at the falling edge
  task automatic tick(input string tag);
    @(negedge clk);
    total++;
    if (rd_valid !== m_rv || {16'd0, rd_sec} !== m_rs || {34'd0, rd_ns} !== m_rn) begin
      bad++;
      $display("FAIL %s actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
               tag, rd_valid, rd_sec, rd_ns, m_rv, m_rs, m_rn);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [47:0] d, input logic re);
    wr_en = we; wr_sel = sel; wr_data = d; rd_en = re;
  endtask

  function automatic logic [47:0] cfg_word(input int k, input int a, input int n);
    return {24'd0, 8'(k), 8'(a), 8'(n)};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(1234);
    m_sec = 0; m_ns = 0; m_rs = 0; m_rn = 0; m_rv = 0;
    m_norm = 0; m_alt = 0; m_k = 0; m_cnt = 0;
    rst_n = 1'b0;
    drive(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_on = 1'b1;
    repeat (4) tick("R1");

    // R1: reset state, read returns zero
    check_val("R1 valid", {63'd0, rd_valid}, 0);
    drive(0, 0, 0, 1); tick("R1");
    check_val("R1 sec", {16'd0, rd_sec}, 0);
    check_val("R1 ns", {34'd0, rd_ns}, 0);

    // R2/R4: start time then pattern 8,8,9
    drive(1, 2'd0, 48'd5, 0);              tick("R2");
    drive(1, 2'd1, 48'd0, 0);              tick("R2");
    drive(1, 2'd2, cfg_word(2, 9, 8), 0);  tick("R4");
    drive(0, 0, 0, 0);
    repeat (3) tick("R4");
    drive(0, 0, 0, 1);                     tick("R4");
    check_val("R4 ns after 8+8+9", {34'd0, rd_ns}, 25);
    check_val("R2 sec loaded", {16'd0, rd_sec}, 5);
    drive(0, 0, 0, 1);
    repeat (6) tick("R4 R8");

    // R5/R6: count zero and the billion wrap
    drive(1, 2'd0, 48'd100, 0);            tick("R2");
    drive(1, 2'd2, cfg_word(0, 200, 9), 0); tick("R5");
    drive(1, 2'd1, 48'd999999995, 0);      tick("R6");
    drive(0, 0, 0, 0);                     tick("R6");
    drive(0, 0, 0, 1);                     tick("R6");
    check_val("R6 sec carry", {16'd0, rd_sec}, 101);
    check_val("R6 ns wrapped", {34'd0, rd_ns}, 4);
    repeat (5) tick("R5");
    drive(0, 0, 0, 1);                     tick("R5");
    check_val("R5 normal only", {34'd0, rd_ns}, 4 + 9 * 6);

    // R9: select 3 write is ignored
    drive(1, 2'd2, cfg_word(0, 0, 10), 0); tick("R9");
    drive(1, 2'd1, 48'd0, 0);              tick("R9");
    drive(1, 2'd3, 48'hFFFF_FFFF_FFFF, 0); tick("R9");
    drive(0, 0, 0, 1);                     tick("R9");
    check_val("R9 no effect", {34'd0, rd_ns}, 10);

    // R7: restart mid pattern
    drive(1, 2'd2, cfg_word(1, 20, 5), 0); tick("R7");
    drive(0, 0, 0, 0);                     tick("R7");
    drive(1, 2'd1, 48'd0, 0);              tick("R7");
    drive(0, 0, 0, 0);                     tick("R7");
    drive(0, 0, 0, 1);                     tick("R7");
    check_val("R7 first step normal", {34'd0, rd_ns}, 5);

    // random mix against the model (R3 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      logic        we, re;
      logic [1:0]  sel;
      logic [47:0] d;
      we  = ($urandom % 100) < 6;
      re  = $urandom % 2;
      sel = 2'($urandom % 4);
      d   = {16'($urandom), 32'($urandom)};
      if (sel == 2'd1) begin
        if ($urandom % 4 == 0) d = 48'd999999000 + 48'($urandom % 1000);
        else                   d = 48'($urandom % 1000000000);
      end
      if (sel == 2'd2) d = cfg_word($urandom % 5, 1 + $urandom % 255, 1 + $urandom % 255);
      drive(we, sel, d, re);
      tick("R3 R8 random");
    end

    drive(0, 0, 0, 0);
    tick("R8");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule